// File: doc/BRIEF.md
# Three-quarter rate check-byte encoder

The block turns a 24-byte payload into a 32-byte protected image, which it delivers as eight 32-bit words. It collects the payload from a byte stream, reverses the byte order, and cuts the result into four groups of six bytes. Each group passes through unchanged and is followed by two check bytes. The first check byte is the XOR of the six bytes. The second is the sum, over positions one to six, of the position number times the count of ones in the byte at that position. Because each group of six grows to eight, the code rate is three quarters.

A block is opened by a byte flagged as start and closed by a byte flagged as end. The whole block is held in registers until the end byte arrives. A block of the right length is then emitted. A block of the wrong length raises a sticky error and emits nothing. Input back-pressure: `in_ready` stays high while the block is being collected and stays low for as long as output words are pending, so a stalled output holds the input off and no byte is lost or repeated. Output back-pressure: a word moves only in a cycle where `out_valid` and `out_ready` are both high, and while `out_ready` is low the word stays where it is.

A companion checker takes the eight words of a block on its own word stream. It recomputes both check bytes for every group and raises a fail flag for the block when either check byte disagrees.

Top module: `check_byte_codec`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0, `length_error` is 0 and `chk_fail` is 0.
- R2: A byte is taken when `in_valid` and `in_ready` are both high. `in_ready` is low whenever `out_valid` is high. Every word of an accepted block appears exactly once.
- R3: Let the accepted payload bytes be b0..b23 in arrival order. The encoded byte stream is built from p0..p23, where pj = b(23-j). Group g (0..3) is encoded as bytes 8g..8g+7. Bytes 8g..8g+5 are p(6g)..p(6g+5).
- R4: Byte 8g+6 of the encoded stream is the XOR of the six payload bytes of group g.
- R5: Byte 8g+7 is the sum over k = 1..6 of k times the number of set bits in the k-th payload byte of group g. A group of six 0xFF bytes gives 168 (0xA8).
- R6: Output word w (0..7) carries encoded bytes 4w..4w+3. Byte 4w sits in bits 7:0 and byte 4w+3 sits in bits 31:24. The words are sent in ascending w.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` is unchanged in the next cycle.
- R8: When a byte flagged `in_eob` is accepted and the block count (counting from the last start byte, including the end byte) is not 24, `length_error` goes to 1 and no output word is produced for that block.
- R9: `length_error` keeps its value until a byte flagged `in_sob` is accepted. That byte clears it, unless the same byte is also an end byte that closes a wrong-length block.
- R10: A byte flagged `in_sob` restarts the count, so bytes taken before it are discarded.
- R11: `chk_ready` is always 1. The checker takes a word whenever `chk_valid` is high. A word flagged `chk_sob` is word 0 of a block. For each group, the checker compares the received XOR byte and weighted-sum byte against values recomputed from the received payload bytes. On any mismatch `chk_fail` goes to 1 one cycle after the group's second word.
- R12: `chk_fail` stays set until a word flagged `chk_sob` is taken, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Block can take a payload byte |
| in_data | input | 8 | Payload byte |
| in_sob | input | 1 | Byte is the first of a block |
| in_eob | input | 1 | Byte is the last of a block |
| out_valid | output | 1 | Encoded word valid |
| out_ready | input | 1 | Sink takes the encoded word |
| out_data | output | 32 | Encoded word, little-endian bytes |
| length_error | output | 1 | Sticky wrong-length flag |
| chk_valid | input | 1 | Checker word valid |
| chk_ready | output | 1 | Checker can take a word (always 1) |
| chk_data | input | 32 | Encoded word to check |
| chk_sob | input | 1 | Word is word 0 of a block |
| chk_fail | output | 1 | A group of the current block failed its checks |

## Verification
The bench checks the all-ones payload, where the weighted sum reaches its ceiling of 168. A design that drops a position weight or lets the sum wrap gives the wrong top byte. Payloads with distinct bytes expose a design that skips the byte reversal, puts the two check bytes in the wrong order, or packs words big-endian, because each of these moves a known value into the wrong lane. Random output stalls catch a word that is dropped, repeated, or changed while held. Blocks of 23 and 25 bytes, and a restart in the middle of a block, catch a design that emits a short block or keeps stale bytes after a restart. Corrupting one check byte and, separately, one payload bit catches a checker that misses either kind of mismatch or never clears its flag.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int GRP_BYTES  = 6;
  localparam int NUM_GROUPS = 4;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 4;
endpackage

// File: rtl/cbc_group_calc.sv
module cbc_group_calc #(
  parameter int GRP = cbc_pkg::GRP_BYTES
) (
  input  logic [GRP*8-1:0] grp_bytes,
  output logic [7:0]       xor_byte,
  output logic [7:0]       wsum_byte
);
  always_comb begin
    xor_byte  = '0;
    wsum_byte = '0;
    for (int k = 0; k < GRP; k++) begin
      xor_byte  = xor_byte ^ grp_bytes[8*k +: 8];
      wsum_byte = wsum_byte + 8'(k + 1) * 8'($countones(grp_bytes[8*k +: 8]));
    end
  end
endmodule

// File: rtl/cbc_encoder.sv
module cbc_encoder #(
  parameter int GRP  = cbc_pkg::GRP_BYTES,
  parameter int NGRP = cbc_pkg::NUM_GROUPS
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_sob,
  input  logic        in_eob,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic        length_error
);
  localparam int BLK   = GRP * NGRP;
  localparam int EGRP  = GRP + 2;
  localparam int ENC   = EGRP * NGRP;
  localparam int NWORD = ENC / cbc_pkg::WORD_BYTES;
  localparam int CW    = $clog2(BLK + 2);
  localparam int WW    = $clog2(NWORD);

  logic [7:0]    pay_q [BLK];
  logic [CW-1:0] cnt_q, base_cnt, next_cnt;
  logic          emit_q;
  logic [WW-1:0] widx_q;
  logic          take;

  assign in_ready  = !emit_q;
  assign out_valid = emit_q;
  assign take      = in_valid && in_ready;

  always_comb begin
    base_cnt = in_sob ? '0 : cnt_q;
    next_cnt = (base_cnt == CW'(BLK + 1)) ? base_cnt : base_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (take && base_cnt < CW'(BLK)) pay_q[base_cnt] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      emit_q       <= 1'b0;
      widx_q       <= '0;
      length_error <= 1'b0;
    end else if (take) begin
      if (in_sob) length_error <= 1'b0;
      if (in_eob) begin
        cnt_q <= '0;
        if (next_cnt == CW'(BLK)) begin
          emit_q <= 1'b1;
          widx_q <= '0;
        end else begin
          length_error <= 1'b1;
        end
      end else begin
        cnt_q <= next_cnt;
      end
    end else if (emit_q && out_ready) begin
      widx_q <= widx_q + 1'b1;
      if (widx_q == WW'(NWORD - 1)) emit_q <= 1'b0;
    end
  end

  logic [7:0] enc_b [ENC];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GRP*8-1:0] gin;
    logic [7:0]       gx, gs;
    for (genvar k = 0; k < GRP; k++) begin : g_byte
      assign gin[8*k +: 8]       = pay_q[BLK-1-(g*GRP+k)];
      assign enc_b[g*EGRP + k]   = gin[8*k +: 8];
    end
    cbc_group_calc #(.GRP(GRP)) u_calc (
      .grp_bytes(gin),
      .xor_byte (gx),
      .wsum_byte(gs)
    );
    assign enc_b[g*EGRP + GRP]     = gx;
    assign enc_b[g*EGRP + GRP + 1] = gs;
  end

  always_comb begin
    for (int b = 0; b < cbc_pkg::WORD_BYTES; b++)
      out_data[8*b +: 8] = enc_b[{widx_q, 2'(b)}];
  end
endmodule

// File: rtl/cbc_checker.sv
module cbc_checker #(
  parameter int GRP = cbc_pkg::GRP_BYTES
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        chk_valid,
  output logic        chk_ready,
  input  logic [31:0] chk_data,
  input  logic        chk_sob,
  output logic        chk_fail
);
  localparam int WPG = (GRP + 2) / cbc_pkg::WORD_BYTES;
  localparam int PW  = $clog2(WPG);

  logic [PW-1:0]           wpos_q, wpos_eff;
  logic [32*(WPG-1)-1:0]   prior_q;
  logic [32*WPG-1:0]       full;
  logic [7:0]              calc_x, calc_s;
  logic                    bad;

  assign chk_ready = 1'b1;
  assign wpos_eff  = chk_sob ? '0 : wpos_q;
  assign full      = {chk_data, prior_q};

  cbc_group_calc #(.GRP(GRP)) u_calc (
    .grp_bytes(full[GRP*8-1:0]),
    .xor_byte (calc_x),
    .wsum_byte(calc_s)
  );

  assign bad = (calc_x != full[GRP*8 +: 8]) || (calc_s != full[GRP*8+8 +: 8]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wpos_q   <= '0;
      prior_q  <= '0;
      chk_fail <= 1'b0;
    end else if (chk_valid) begin
      if (chk_sob) chk_fail <= 1'b0;
      if (wpos_eff == PW'(WPG - 1)) begin
        wpos_q <= '0;
        if (bad) chk_fail <= 1'b1;
      end else begin
        prior_q[32*wpos_eff +: 32] <= chk_data;
        wpos_q <= wpos_eff + 1'b1;
      end
    end
  end
endmodule

// File: rtl/check_byte_codec.sv
module check_byte_codec #(
  parameter int GRP  = cbc_pkg::GRP_BYTES,
  parameter int NGRP = cbc_pkg::NUM_GROUPS
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_sob,
  input  logic        in_eob,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic        length_error,
  input  logic        chk_valid,
  output logic        chk_ready,
  input  logic [31:0] chk_data,
  input  logic        chk_sob,
  output logic        chk_fail
);
  cbc_encoder #(.GRP(GRP), .NGRP(NGRP)) u_enc (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sob(in_sob), .in_eob(in_eob),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .length_error(length_error)
  );

  cbc_checker #(.GRP(GRP)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .chk_valid(chk_valid), .chk_ready(chk_ready),
    .chk_data(chk_data), .chk_sob(chk_sob), .chk_fail(chk_fail)
  );
endmodule

// File: rtl/cbc_props.sv
module cbc_props (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_sob,
  input logic        in_eob,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        length_error,
  input logic        chk_valid,
  input logic        chk_sob,
  input logic        chk_fail
);
  logic        odd_q;
  logic [31:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      odd_q  <= 1'b0;
      prev_q <= '0;
    end else if (out_valid && out_ready) begin
      odd_q  <= !odd_q;
      prev_q <= out_data;
    end
  end

  assert_ready_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_xor_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && odd_q) |-> (out_data[23:16] ==
      (prev_q[7:0] ^ prev_q[15:8] ^ prev_q[23:16] ^ prev_q[31:24] ^
       out_data[7:0] ^ out_data[15:8])));

  assert_lenerr_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(length_error) |-> ($past(in_valid && in_ready && in_eob) && !out_valid));

  assert_lenerr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(length_error) |-> $past(in_valid && in_ready && in_sob));

  assert_fail_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chk_fail) |-> $past(chk_valid && chk_sob));
endmodule

bind check_byte_codec cbc_props u_props (
  .clk(clk), .rst_n(rst_n),
  .in_valid(in_valid), .in_ready(in_ready), .in_sob(in_sob), .in_eob(in_eob),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .length_error(length_error),
  .chk_valid(chk_valid), .chk_sob(chk_sob), .chk_fail(chk_fail)
);

// File: tb/test_check_byte_codec.sv
module test_check_byte_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sob = 1'b0, in_eob = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid, length_error, chk_ready, chk_fail;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        chk_valid = 1'b0, chk_sob = 1'b0;
  logic [31:0] chk_data = '0;

  always #5 clk = !clk;

  check_byte_codec i_check_byte_codec (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sob(in_sob), .in_eob(in_eob),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .length_error(length_error),
    .chk_valid(chk_valid), .chk_ready(chk_ready), .chk_data(chk_data),
    .chk_sob(chk_sob), .chk_fail(chk_fail)
  );

  int total = 0, bad = 0, words_seen = 0;
  logic [31:0] expq[$];
  logic [7:0]  pl [24];
  logic [31:0] ew [8];
  bit          stall_mode = 0, done = 0;
  int          rc = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model built from the requirements (R3..R6)
  task automatic build_expected();
    logic [7:0] e [32];
    logic [7:0] x, s;
    for (int g = 0; g < 4; g++) begin
      x = 0; s = 0;
      for (int k = 0; k < 6; k++) begin
        e[g*8+k] = pl[23-(g*6+k)];
        x ^= e[g*8+k];
        s += 8'(k+1) * 8'($countones(e[g*8+k]));
      end
      e[g*8+6] = x;
      e[g*8+7] = s;
    end
    for (int w = 0; w < 8; w++) ew[w] = {e[4*w+3], e[4*w+2], e[4*w+1], e[4*w]};
  endtask

  task automatic send_byte(input logic [7:0] d, input bit sob, input bit eob);
    @(negedge clk);
    in_valid = 1; in_data = d; in_sob = sob; in_eob = eob;
    forever begin
      #2;
      if (in_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_sob = 0; in_eob = 0;
  endtask

  task automatic send_block();
    build_expected();
    for (int w = 0; w < 8; w++) expq.push_back(ew[w]);
    for (int i = 0; i < 24; i++) send_byte(pl[i], i == 0, i == 23);
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 300 && expq.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(expq.size() == 0, req, expq.size(), 0);
  endtask

  task automatic send_chk(input int corrupt_word, input logic [31:0] flip);
    for (int w = 0; w < 8; w++) begin
      @(negedge clk);
      chk_valid = 1; chk_sob = (w == 0);
      chk_data = (w == corrupt_word) ? (ew[w] ^ flip) : ew[w];
    end
    @(negedge clk);
    chk_valid = 0; chk_sob = 0;
    #2;
  endtask

  // out_ready pattern
  always @(negedge clk) begin
    rc++;
    out_ready <= stall_mode ? ((rc % 3) != 0) : 1'b1;
  end

  // Monitor: pops expected words (R2, R3, R4, R5, R6) and checks held words (R7)
  logic        held_v = 0;
  logic [31:0] held_d;
  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      if (held_v) check(out_valid && out_data == held_d, "R7 hold", out_data, held_d);
      held_v = out_valid && !out_ready;
      held_d = out_data;
      if (out_valid) check(!in_ready, "R2 ready low while emitting", in_ready, 0);
      if (out_valid && out_ready) begin
        words_seen++;
        if (expq.size() == 0) check(0, "R2 unexpected word", out_data, 0);
        else begin
          logic [31:0] ex;
          ex = expq.pop_front();
          check(out_data == ex, "R3 R4 R5 R6 word", out_data, ex);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ws;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    // R1 reset state
    check(in_ready == 1, "R1 in_ready", in_ready, 1);
    check(out_valid == 0, "R1 out_valid", out_valid, 0);
    check(length_error == 0, "R1 length_error", length_error, 0);
    check(chk_fail == 0, "R1 chk_fail", chk_fail, 0);
    check(chk_ready == 1, "R11 chk_ready", chk_ready, 1);

    // R5 ceiling: all ones
    for (int i = 0; i < 24; i++) pl[i] = 8'hFF;
    send_block(); drain("R5 all-ones block drained");
    check(ew[1] == 32'hA800FFFF, "R5 ref word", ew[1], 32'hA800FFFF);

    // R3 R6 distinct bytes
    for (int i = 0; i < 24; i++) pl[i] = 8'(i + 1);
    send_block(); drain("R3 ascending block drained");

    // all zeros
    for (int i = 0; i < 24; i++) pl[i] = 8'h00;
    send_block(); drain("R4 zero block drained");

    // R7 R2 with stalls, mixed pattern
    stall_mode = 1;
    for (int i = 0; i < 24; i++) pl[i] = 8'((i * 37) ^ 8'h5A);
    send_block();
    for (int i = 0; i < 24; i++) pl[i] = 8'((i * 113) + 7);
    send_block(); drain("R2 stalled blocks drained");
    stall_mode = 0;

    // R8 short block
    ws = words_seen;
    for (int i = 0; i < 23; i++) send_byte(8'(i), i == 0, i == 22);
    repeat (20) @(negedge clk); #2;
    check(length_error == 1, "R8 short block flag", length_error, 1);
    check(words_seen == ws, "R8 short block no words", words_seen, ws);
    check(out_valid == 0, "R8 short block out_valid", out_valid, 0);
    check(in_ready == 1, "R8 in_ready after error", in_ready, 1);

    // R9 flag kept then cleared by start byte
    send_byte(8'h11, 1, 0);
    #2;
    check(length_error == 0, "R9 cleared by sob", length_error, 0);
    for (int i = 0; i < 24; i++) pl[i] = 8'(8'hC3 ^ i);
    send_block(); drain("R9 good block after error");
    check(length_error == 0, "R9 stays clear", length_error, 0);

    // R8 long block
    ws = words_seen;
    for (int i = 0; i < 25; i++) send_byte(8'(i), i == 0, i == 24);
    repeat (20) @(negedge clk); #2;
    check(length_error == 1, "R8 long block flag", length_error, 1);
    check(words_seen == ws, "R8 long block no words", words_seen, ws);

    // R10 restart mid-block
    for (int i = 0; i < 5; i++) send_byte(8'hEE, i == 0, 0);
    for (int i = 0; i < 24; i++) pl[i] = 8'(255 - 9 * i);
    send_block(); drain("R10 restart block drained");
    check(length_error == 0, "R10 restart clears flag", length_error, 0);

    // R11 R12 checker
    for (int i = 0; i < 24; i++) pl[i] = 8'(i * 29 + 3);
    build_expected();
    send_chk(-1, 0);
    check(chk_fail == 0, "R11 clean block", chk_fail, 0);
    send_chk(3, 32'h0100_0000);
    check(chk_fail == 1, "R11 bad weighted byte", chk_fail, 1);
    send_chk(-1, 0);
    check(chk_fail == 0, "R12 cleared by sob", chk_fail, 0);
    send_chk(4, 32'h0000_0010);
    check(chk_fail == 1, "R11 bad payload bit", chk_fail, 1);
    send_chk(5, 32'h0001_0000);
    check(chk_fail == 1, "R11 bad xor byte", chk_fail, 1);
    repeat (5) @(negedge clk); #2;
    check(chk_fail == 1, "R12 flag held", chk_fail, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule